// File: doc/BRIEF.md
# Streaming TLV Parameter Parser

The block takes a stream of type-length-value records packed into 32-bit words and rebuilds each record one byte per clock. A `start_i` pulse loads the total byte count of the stream and clears the parser. The block then pulls words through a valid/ready port and takes the bytes of each word lowest byte first. It stops at the total byte count, so any later bytes in the last word are dropped. For each finished record it pulses `rec_valid_o` with the record's type and its little-endian value of up to 64 bits.

The record type takes one or two bytes. The first byte gives type bits 6:0, and its bit 7 says whether a second byte follows. A length byte comes next, then that many value bytes. A length of zero is legal and gives a value of zero. A checking stage reads every finished record. It keeps three 16-bit limits, clamping any larger value to 0xFFFF. It rejects values the consumer cannot work with and ignores any type it does not know. When the stream ends, or the parse stops on an error, `done_o` rises and stays high, with an error code beside it, until the next start.

Top module: `tlv_param_parser`

## Requirements
- R1: The first type byte gives type bits 6:0. If its bit 7 is 1, the next byte is a type extension, and the type becomes the first byte's low 7 bits OR (extension byte << 7). If bit 7 is 0, the next byte is the length.
- R2: A length byte greater than 8 stops the parse. `done_o` rises with `error_o`=1 and `error_code_o`=1, and no record is emitted for that entry.
- R3: A length byte of 0 completes the record right away with value 0. The next byte is read as a new type byte.
- R4: Value byte k, counted from 0, lands at value bits 8k+7:8k. The record completes once `length` value bytes have arrived. The value is cleared at each new type byte, so a short record never keeps bytes from an earlier, longer one.
- R5: Each accepted word is taken as bytes 7:0, 15:8, 23:16, 31:24, one per clock. `word_ready_o` stays low while a word is being consumed. Bytes at or past `total_len_i` are never parsed.
- R6: If the stream ends while a type extension byte is still awaited, the parser reports `error_code_o`=2. If it ends while the length byte or value bytes are still awaited, it reports `error_code_o`=3.
- R7: On start, the limits reload to their parameter defaults. Type 1 sets the header-length limit, type 2 the frame-count limit and type 3 the segment-count limit. Each takes min(value, 0xFFFF).
- R8: The stream is rejected with `error_code_o`=4 by any of these records: type 7 (compatibility) with a nonzero value; type 4 (header segment count) with value 0; type 5 or 6 (queue-size granularity) whose value is not a power of two no greater than MIN_QSIZE (default 64).
- R9: Types the checking stage does not recognise still produce a record. They change no limit and raise no error.
- R10: A stream that ends exactly at a record boundary finishes with `done_o`=1, `error_o`=0 and `error_code_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Pulse: load total length, clear the parser, reload the limits |
| total_len_i | input | 16 | Total stream length in bytes, sampled on start |
| word_valid_i | input | 1 | Input word valid |
| word_i | input | 32 | Input word, lowest byte parsed first |
| word_ready_o | output | 1 | Block can accept a word |
| rec_valid_o | output | 1 | One-cycle pulse: a record is complete |
| rec_type_o | output | 15 | Type of the completed record |
| rec_value_o | output | 64 | Value of the completed record |
| done_o | output | 1 | Parse finished; held until the next start |
| error_o | output | 1 | Parse ended on an error |
| error_code_o | output | 3 | 0 none, 1 oversize length, 2 truncated type, 3 truncated length/value, 4 rejected value |
| hdr_len_lim_o | output | 16 | Stored header-length limit |
| frame_lim_o | output | 16 | Stored frame-count limit |
| seg_lim_o | output | 16 | Stored segment-count limit |

## Verification
The bench runs every value length from 0 through 8 behind a two-byte type. A part-select placed at the wrong offset, or an off-by-one in the completion count, shows up as a wrong value or a missing record. It cuts one stream short at every byte position and checks the truncation code at each cut. A design that does not tell the extension state apart from the length and value states reports the wrong code, and one that parses past the total length reports success. It runs every granularity value from 0 to 70, plus the compatibility and segment-count edge values, so a loose divisibility test either accepts a bad value or rejects a good one. It also checks that a short record placed after a long one carries none of the long record's bytes.

// File: rtl/tlv_pkg.sv
package tlv_pkg;
  typedef enum logic [1:0] {ST_TYPE, ST_TYPE_EXT, ST_LEN, ST_VAL} tlv_state_e;

  localparam logic [2:0] ERR_NONE      = 3'd0;
  localparam logic [2:0] ERR_OVERSIZE  = 3'd1;
  localparam logic [2:0] ERR_TRUNC_TYP = 3'd2;
  localparam logic [2:0] ERR_TRUNC_VAL = 3'd3;
  localparam logic [2:0] ERR_REJECT    = 3'd4;

  localparam int T_HDR_LEN  = 1;
  localparam int T_FRAMES   = 2;
  localparam int T_SEGS     = 3;
  localparam int T_HDR_SEGS = 4;
  localparam int T_RX_GRAN  = 5;
  localparam int T_TX_GRAN  = 6;
  localparam int T_COMPAT   = 7;
endpackage

// File: rtl/tlv_byte_fsm.sv
module tlv_byte_fsm
  import tlv_pkg::*;
#(
  parameter int TYPE_W    = 15,
  parameter int MAX_BYTES = 8,
  localparam int VAL_W    = 8 * MAX_BYTES,
  localparam int OFF_W    = $clog2(MAX_BYTES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clear_i,
  input  logic              byte_valid_i,
  input  logic [7:0]        byte_i,
  output logic              rec_valid_o,
  output logic [TYPE_W-1:0] type_o,
  output logic [VAL_W-1:0]  value_o,
  output logic              ovf_o,
  output tlv_state_e        state_o
);
  tlv_state_e        state_q;
  logic [TYPE_W-1:0] type_q;
  logic [VAL_W-1:0]  value_q;
  logic [OFF_W-1:0]  off_q;
  logic [7:0]        len_q;
  logic              rec_q, ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_TYPE;
      type_q  <= '0;
      value_q <= '0;
      off_q   <= '0;
      len_q   <= '0;
      rec_q   <= 1'b0;
      ovf_q   <= 1'b0;
    end else begin
      rec_q <= 1'b0;
      ovf_q <= 1'b0;
      if (clear_i) begin
        state_q <= ST_TYPE;
        type_q  <= '0;
        value_q <= '0;
        off_q   <= '0;
        len_q   <= '0;
      end else if (byte_valid_i) begin
        unique case (state_q)
          ST_TYPE: begin
            type_q  <= TYPE_W'(byte_i[6:0]);
            value_q <= '0;
            off_q   <= '0;
            state_q <= byte_i[7] ? ST_TYPE_EXT : ST_LEN;
          end
          ST_TYPE_EXT: begin
            type_q  <= type_q | (TYPE_W'(byte_i) << 7);
            state_q <= ST_LEN;
          end
          ST_LEN: begin
            len_q <= byte_i;
            if (byte_i > 8'(MAX_BYTES)) begin
              ovf_q <= 1'b1;
            end else if (byte_i == 8'd0) begin
              rec_q   <= 1'b1;
              state_q <= ST_TYPE;
            end else begin
              state_q <= ST_VAL;
            end
          end
          ST_VAL: begin
            value_q[{off_q, 3'b000} +: 8] <= byte_i;
            off_q <= off_q + 1'b1;
            if (8'(off_q) + 8'd1 == len_q) begin
              rec_q   <= 1'b1;
              state_q <= ST_TYPE;
            end
          end
          default: state_q <= ST_TYPE;
        endcase
      end
    end
  end

  assign rec_valid_o = rec_q;
  assign type_o      = type_q;
  assign value_o     = value_q;
  assign ovf_o       = ovf_q;
  assign state_o     = state_q;

  // R4
  val_off_in_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_q == ST_VAL |-> 8'(off_q) < len_q);
  // R2
  rec_len_legal_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_q |-> len_q <= 8'(MAX_BYTES));
endmodule

// File: rtl/tlv_param_check.sv
module tlv_param_check
  import tlv_pkg::*;
#(
  parameter int TYPE_W    = 15,
  parameter int VAL_W     = 64,
  parameter int LIM_W     = 16,
  parameter int MIN_QSIZE = 64,
  parameter logic [LIM_W-1:0] DEF_HDR_LEN = 16'd192,
  parameter logic [LIM_W-1:0] DEF_FRAMES  = 16'd32,
  parameter logic [LIM_W-1:0] DEF_SEGS    = 16'd64
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              rec_valid_i,
  input  logic [TYPE_W-1:0] type_i,
  input  logic [VAL_W-1:0]  value_i,
  output logic              reject_o,
  output logic [LIM_W-1:0]  hdr_len_o,
  output logic [LIM_W-1:0]  frames_o,
  output logic [LIM_W-1:0]  segs_o
);
  logic [LIM_W-1:0] hdr_q, frm_q, seg_q, sat;
  logic             gran_ok;

  assign sat     = (|value_i[VAL_W-1:LIM_W]) ? '1 : value_i[LIM_W-1:0];
  assign gran_ok = (value_i != '0) && ((value_i & (value_i - 1'b1)) == '0)
                   && (value_i <= VAL_W'(MIN_QSIZE));

  always_comb begin
    reject_o = 1'b0;
    if (rec_valid_i) begin
      if (type_i == TYPE_W'(T_COMPAT))                                  reject_o = (value_i != '0);
      else if (type_i == TYPE_W'(T_HDR_SEGS))                           reject_o = (value_i == '0);
      else if (type_i == TYPE_W'(T_RX_GRAN) || type_i == TYPE_W'(T_TX_GRAN)) reject_o = !gran_ok;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hdr_q <= DEF_HDR_LEN;
      frm_q <= DEF_FRAMES;
      seg_q <= DEF_SEGS;
    end else if (load_i) begin
      hdr_q <= DEF_HDR_LEN;
      frm_q <= DEF_FRAMES;
      seg_q <= DEF_SEGS;
    end else if (rec_valid_i) begin
      if (type_i == TYPE_W'(T_HDR_LEN)) hdr_q <= sat;
      if (type_i == TYPE_W'(T_FRAMES))  frm_q <= sat;
      if (type_i == TYPE_W'(T_SEGS))    seg_q <= sat;
    end
  end

  assign hdr_len_o = hdr_q;
  assign frames_o  = frm_q;
  assign segs_o    = seg_q;

  // R7
  hdr_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rec_valid_i && !load_i && type_i == TYPE_W'(T_HDR_LEN) && (|value_i[VAL_W-1:LIM_W])
    |=> hdr_q == '1);
endmodule

// File: rtl/tlv_param_parser.sv
module tlv_param_parser
  import tlv_pkg::*;
#(
  parameter int LEN_W     = 16,
  parameter int TYPE_W    = 15,
  parameter int MAX_BYTES = 8,
  parameter int LIM_W     = 16,
  parameter int MIN_QSIZE = 64,
  parameter logic [LIM_W-1:0] DEF_HDR_LEN = 16'd192,
  parameter logic [LIM_W-1:0] DEF_FRAMES  = 16'd32,
  parameter logic [LIM_W-1:0] DEF_SEGS    = 16'd64,
  localparam int VAL_W = 8 * MAX_BYTES
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic [LEN_W-1:0]  total_len_i,
  input  logic              word_valid_i,
  input  logic [31:0]       word_i,
  output logic              word_ready_o,
  output logic              rec_valid_o,
  output logic [TYPE_W-1:0] rec_type_o,
  output logic [VAL_W-1:0]  rec_value_o,
  output logic              done_o,
  output logic              error_o,
  output logic [2:0]        error_code_o,
  output logic [LIM_W-1:0]  hdr_len_lim_o,
  output logic [LIM_W-1:0]  frame_lim_o,
  output logic [LIM_W-1:0]  seg_lim_o
);
  logic             run_q, held_q, done_q;
  logic [31:0]      word_q;
  logic [1:0]       bidx_q;
  logic [LEN_W-1:0] cnt_q, total_q;
  logic [2:0]       code_q;
  logic             ovf, reject, stop, at_end, feed, accept;
  logic [7:0]       cur_byte;
  tlv_state_e       pstate;

  assign stop     = ovf | reject;
  assign at_end   = (cnt_q == total_q);
  assign feed     = run_q && held_q && !stop && !at_end;
  assign word_ready_o = run_q && !held_q && !stop && !at_end;
  assign accept   = word_valid_i && word_ready_o;
  assign cur_byte = word_q[{bidx_q, 3'b000} +: 8];

  tlv_byte_fsm #(.TYPE_W(TYPE_W), .MAX_BYTES(MAX_BYTES)) u_fsm (
    .clk_i, .rst_ni,
    .clear_i     (start_i),
    .byte_valid_i(feed),
    .byte_i      (cur_byte),
    .rec_valid_o (rec_valid_o),
    .type_o      (rec_type_o),
    .value_o     (rec_value_o),
    .ovf_o       (ovf),
    .state_o     (pstate)
  );

  tlv_param_check #(
    .TYPE_W(TYPE_W), .VAL_W(VAL_W), .LIM_W(LIM_W), .MIN_QSIZE(MIN_QSIZE),
    .DEF_HDR_LEN(DEF_HDR_LEN), .DEF_FRAMES(DEF_FRAMES), .DEF_SEGS(DEF_SEGS)
  ) u_chk (
    .clk_i, .rst_ni,
    .load_i     (start_i),
    .rec_valid_i(rec_valid_o),
    .type_i     (rec_type_o),
    .value_i    (rec_value_o),
    .reject_o   (reject),
    .hdr_len_o  (hdr_len_lim_o),
    .frames_o   (frame_lim_o),
    .segs_o     (seg_lim_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      held_q  <= 1'b0;
      done_q  <= 1'b0;
      word_q  <= '0;
      bidx_q  <= '0;
      cnt_q   <= '0;
      total_q <= '0;
      code_q  <= ERR_NONE;
    end else if (start_i) begin
      run_q   <= 1'b1;
      held_q  <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
      total_q <= total_len_i;
      code_q  <= ERR_NONE;
    end else if (run_q) begin
      if (accept) begin
        held_q <= 1'b1;
        word_q <= word_i;
        bidx_q <= '0;
      end
      if (feed) begin
        cnt_q  <= cnt_q + 1'b1;
        bidx_q <= bidx_q + 1'b1;
        if (bidx_q == 2'd3 || cnt_q + 1'b1 == total_q) held_q <= 1'b0;
      end
      if (ovf || reject || at_end) begin
        run_q  <= 1'b0;
        held_q <= 1'b0;
        done_q <= 1'b1;
        if (ovf)                         code_q <= ERR_OVERSIZE;
        else if (reject)                 code_q <= ERR_REJECT;
        else if (pstate == ST_TYPE_EXT)  code_q <= ERR_TRUNC_TYP;
        else if (pstate != ST_TYPE)      code_q <= ERR_TRUNC_VAL;
        else                             code_q <= ERR_NONE;
      end
    end
  end

  assign done_o       = done_q;
  assign error_o      = (code_q != ERR_NONE);
  assign error_code_o = code_q;

  // R5
  one_word_at_a_time_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept && !start_i |=> !word_ready_o);
  // R10
  clean_done_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q && !error_o |-> cnt_q == total_q);
  // R2
  error_has_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_q) && $past(ovf) |-> code_q == ERR_OVERSIZE);
endmodule

// File: tb/tb_tlv_param_parser.sv
module tb_tlv_param_parser;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0;
  logic [15:0] total_len_i = '0;
  logic        word_valid_i = 1'b0;
  logic [31:0] word_i = '0;
  logic        word_ready_o, rec_valid_o, done_o, error_o;
  logic [14:0] rec_type_o;
  logic [63:0] rec_value_o;
  logic [2:0]  error_code_o;
  logic [15:0] hdr_len_lim_o, frame_lim_o, seg_lim_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  tlv_param_parser dut (.*);

  int n_chk = 0, n_fail = 0;
  logic [7:0]  sbuf [0:63];
  int          rec_n;
  logic [14:0] rtype [0:15];
  logic [63:0] rval  [0:15];

  always @(negedge clk_i) begin
    if (rec_valid_o && rec_n < 16) begin
      rtype[rec_n] = rec_type_o;
      rval[rec_n]  = rec_value_o;
    end
    if (rec_valid_o) rec_n++;
  end

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_buf();
    for (int i = 0; i < 64; i++) sbuf[i] = 8'h00;
  endtask

  task automatic run_stream(input int total);
    int nw;
    nw = (total + 3) / 4;
    @(negedge clk_i);
    rec_n = 0;
    start_i = 1'b1;
    total_len_i = 16'(total);
    @(negedge clk_i);
    start_i = 1'b0;
    for (int w = 0; w < nw; w++) begin
      word_valid_i = 1'b1;
      word_i = {sbuf[4*w+3], sbuf[4*w+2], sbuf[4*w+1], sbuf[4*w]};
      while (!word_ready_o && !done_o) @(negedge clk_i);
      if (done_o) break;
      @(negedge clk_i);
      word_valid_i = 1'b0;
    end
    word_valid_i = 1'b0;
    for (int t = 0; t < 200 && !done_o; t++) @(negedge clk_i);
    @(negedge clk_i);
  endtask

  // one-byte type, value given as len bytes little-endian
  task automatic put_rec(inout int p, input int typ, input int len, input logic [63:0] v);
    sbuf[p++] = 8'(typ);
    sbuf[p++] = 8'(len);
    for (int k = 0; k < len; k++) sbuf[p++] = v[8*k +: 8];
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", n_chk + 1 - n_fail, n_chk + 1);
    $finish;
  end

  initial begin
    int p;
    logic [63:0] ev;
    logic [14:0] et;
    repeat (3) @(negedge clk_i);
    // reset state
    check("R5 reset ready", word_ready_o, 0);
    check("R10 reset done", done_o, 0);
    check("R7 reset hdr default", hdr_len_lim_o, 192);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 R3 R4 R9: sweep lengths 0..8 behind a two-byte type
    for (int len = 0; len <= 8; len++) begin
      clear_buf();
      et = 15'(16'h0100 + 16'(len * 37));
      sbuf[0] = 8'h80 | 8'(et[6:0]);
      sbuf[1] = 8'(et >> 7);
      sbuf[2] = 8'(len);
      ev = '0;
      for (int k = 0; k < len; k++) begin
        sbuf[3+k] = 8'(len * 16 + k + 1);
        ev[8*k +: 8] = 8'(len * 16 + k + 1);
      end
      run_stream(3 + len);
      check("R1 R4 record count", 64'(rec_n), 1);
      check("R1 ext type", 64'(rtype[0]), 64'(et));
      check(len == 0 ? "R3 zero length value" : "R4 le value", rval[0], ev);
      check("R10 clean code", {error_o, error_code_o}, 0);
      check("R9 limits untouched", {hdr_len_lim_o, frame_lim_o, seg_lim_o}, {16'd192, 16'd32, 16'd64});
    end

    // R4: value cleared between records
    clear_buf(); p = 0;
    put_rec(p, 8'h30, 8, 64'hFFFF_FFFF_FFFF_FFFF);
    put_rec(p, 8'h31, 1, 64'h05);
    put_rec(p, 8'h32, 0, 64'h0);
    run_stream(p);
    check("R4 long record", rval[0], 64'hFFFF_FFFF_FFFF_FFFF);
    check("R4 short cleared", rval[1], 64'h5);
    check("R3 zero after long", rval[2], 64'h0);
    check("R1 short type", 64'(rtype[1]), 64'h31);

    // R7: limits and saturation
    clear_buf(); p = 0;
    put_rec(p, 1, 3, 64'h012345);
    put_rec(p, 2, 2, 64'h1234);
    put_rec(p, 3, 0, 64'h0);
    run_stream(p);
    check("R7 hdr saturated", hdr_len_lim_o, 16'hFFFF);
    check("R7 frames", frame_lim_o, 16'h1234);
    check("R7 segs zero", seg_lim_o, 16'h0);
    check("R10 limits stream ok", error_code_o, 0);
    clear_buf(); p = 0;
    put_rec(p, 8'h40, 0, 64'h0);
    run_stream(p);
    check("R7 defaults reloaded", {hdr_len_lim_o, frame_lim_o, seg_lim_o}, {16'd192, 16'd32, 16'd64});

    // R2: oversize length
    clear_buf();
    sbuf[0] = 8'h10; sbuf[1] = 8'd9;
    for (int k = 2; k < 16; k++) sbuf[k] = 8'h00;
    run_stream(16);
    check("R2 done", done_o, 1);
    check("R2 code", error_code_o, 1);
    check("R2 no record", 64'(rec_n), 0);

    // R5 R6: truncate at every position; bytes past total in last word ignored
    clear_buf();
    sbuf[0] = 8'h85; sbuf[1] = 8'h01; sbuf[2] = 8'h02; sbuf[3] = 8'hAA;
    sbuf[4] = 8'hBB; sbuf[5] = 8'h85; sbuf[6] = 8'h01; sbuf[7] = 8'h05;
    for (int t = 1; t <= 6; t++) begin
      run_stream(t);
      if (t == 1 || t == 6) check("R6 truncated type", error_code_o, 2);
      else if (t == 5) check("R5 R10 full record", error_code_o, 0);
      else check("R6 truncated value", error_code_o, 3);
      if (t == 5) check("R5 byte order", rval[0], 64'hBBAA);
      if (t == 5) check("R1 type 133", 64'(rtype[0]), 133);
    end

    // R8: compatibility, header segment count, granularity sweep
    clear_buf(); p = 0; put_rec(p, 7, 1, 64'h0); run_stream(p);
    check("R8 compat zero ok", error_code_o, 0);
    clear_buf(); p = 0; put_rec(p, 7, 2, 64'h0400); run_stream(p);
    check("R8 compat nonzero", error_code_o, 4);
    clear_buf(); p = 0; put_rec(p, 4, 0, 64'h0); run_stream(p);
    check("R8 hdr segs zero", error_code_o, 4);
    clear_buf(); p = 0; put_rec(p, 4, 1, 64'h1); run_stream(p);
    check("R8 hdr segs one", error_code_o, 0);
    for (int v = 0; v <= 70; v++) begin
      logic ok;
      ok = (v == 1 || v == 2 || v == 4 || v == 8 || v == 16 || v == 32 || v == 64);
      clear_buf(); p = 0;
      put_rec(p, (v % 2) ? 5 : 6, 1, 64'(v));
      put_rec(p, 8'h50, 0, 64'h0);
      run_stream(p);
      check("R8 granularity", error_code_o, ok ? 0 : 4);
      check("R8 records before stop", 64'(rec_n), ok ? 2 : 1);
    end
    clear_buf(); p = 0; put_rec(p, 6, 2, 64'h80); run_stream(p);
    check("R8 granularity 128", error_code_o, 4);

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule